// File: doc/BRIEF.md
# Serial Port Power-State Sequencer

This block steps a serial controller between four power states: awake, a light sleep that stops only the clock oscillator, a deep sleep that also stops the charge pump feeding the line drivers, and a power-save state. Power-save stops both resources and also fences the core off from the host bus strobes, address and data. Entry is requested by a sleep bit in a control register, by a dedicated power-save pin, or by both. A separate pump-off pin deepens light sleep into deep sleep. The oscillator and charge pump themselves sit outside the block. It only drives their enable lines.

The block goes to sleep only when it is quiet. That means both FIFOs are empty, no interrupt is waiting, no transmit data is queued and no activity is seen. The receive line is watched in every state, so a receive edge always brings the block back to awake. Every return to awake raises a wake interrupt, which stays set until software reads the interrupt status register. Deep sleep and power-save stop the charge pump. After either of them, `ready` is held low for a recovery window that models the pump settling time. The window is computed from the clock frequency and a recovery time in microseconds.

Top module: `lp_power_ctrl`

## Requirements
- R1: After synchronous reset, `mode` is 0 (awake), `osc_en`=1, `pump_en`=1, `bus_iso`=0, `wake_irq`=0 and `ready`=1. `mode` encodes awake=0, light sleep=1, deep sleep=2, power-save=3.
- R2: The block leaves awake only in a cycle where all of these hold: both FIFO-empty inputs are high, `irq_pending`, `wake_irq`, `tx_pending`, `rx_edge` and `host_access` are low, and `ready` is high. Otherwise it stays awake. The state changes on the clock edge that samples the request.
- R3: From awake, `sw_sleep_en`=1 with `psave_pin`=0 under the R2 conditions enters light sleep. In light sleep `osc_en`=0 and `pump_en`=1.
- R4: `pump_off_pin` moves light sleep to deep sleep (`osc_en`=0, `pump_en`=0). In awake it has no effect: awake never goes directly to deep sleep.
- R5: `psave_pin`=1 enters power-save. From awake this needs the R2 conditions. From light or deep sleep it takes effect directly. It takes priority over `sw_sleep_en`. In power-save `osc_en`=0, `pump_en`=0 and `bus_iso`=1.
- R6: Light or deep sleep returns to awake on `rx_edge`, `host_access`, `tx_pending`, or `sw_sleep_en` going low. A wake takes priority over a deeper transition in the same cycle.
- R7: Power-save returns to awake only on `rx_edge` or on `psave_pin` going low. `host_access`, `tx_pending` and `sw_sleep_en` have no effect there.
- R8: Every return to awake sets `wake_irq` on that same edge. `isr_read` clears it one edge later. If a set and a clear fall on the same edge, the set wins.
- R9: After leaving deep sleep or power-save, `ready` stays low for RECOVER_CYCLES = CLK_MHZ*RECOVER_US cycles, counting the exit edge, and then goes high. After leaving light sleep, `ready` is high at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_sleep_en | input | 1 | Sleep-enable register bit |
| psave_pin | input | 1 | Hardware power-save request |
| pump_off_pin | input | 1 | Charge-pump shutdown request, acts only when asleep |
| rx_edge | input | 1 | Receive line activity pulse |
| host_access | input | 1 | Host bus access strobe |
| tx_pending | input | 1 | Transmit data waiting |
| rx_fifo_empty | input | 1 | Receive FIFO empty |
| tx_fifo_empty | input | 1 | Transmit FIFO empty |
| irq_pending | input | 1 | Another interrupt is waiting |
| isr_read | input | 1 | Interrupt status register read |
| osc_en | output | 1 | Oscillator enable |
| pump_en | output | 1 | Charge-pump enable |
| bus_iso | output | 1 | Host bus isolation gate |
| wake_irq | output | 1 | Wake-up interrupt |
| ready | output | 1 | Awake and charge pump recovered |
| mode | output | 2 | Current power state |

## Verification
The hardest point to reach is the last cycle of the recovery window after a deep-sleep or power-save exit. Getting there takes a three-step walk through light sleep with the pump pin held. After that, the counter runs for thousands of cycles while the wake interrupt also blocks re-entry. Directed sequences make this walk for each exit path and check `ready` on every cycle of the window. Seeded random traffic then mixes requests, activity and status reads against a cycle model kept in the bench.

// File: rtl/lp_pkg.sv
package lp_pkg;
  typedef enum logic [1:0] {
    PM_AWAKE   = 2'd0,
    PM_PARTIAL = 2'd1,
    PM_FULL    = 2'd2,
    PM_PSAVE   = 2'd3
  } pm_state_t;
endpackage

// File: rtl/lp_activity.sv
// Entry and wake qualification, purely combinational.
module lp_activity (
  input  logic sw_sleep_en,
  input  logic psave_pin,
  input  logic rx_edge,
  input  logic host_access,
  input  logic tx_pending,
  input  logic rx_fifo_empty,
  input  logic tx_fifo_empty,
  input  logic irq_pending,
  input  logic wake_flag,
  input  logic recov_done,
  output logic entry_ok,
  output logic wake_light,
  output logic wake_psave
);
  logic quiet_fifo;
  logic quiet_line;

  assign quiet_fifo = rx_fifo_empty & tx_fifo_empty & ~tx_pending;
  assign quiet_line = ~rx_edge & ~host_access;
  assign entry_ok   = quiet_fifo & quiet_line & ~irq_pending & ~wake_flag & recov_done;
  // host side is fenced off in power-save, so only the line and the pin count
  assign wake_light = rx_edge | host_access | tx_pending | ~sw_sleep_en;
  assign wake_psave = rx_edge | ~psave_pin;
endmodule

// File: rtl/lp_recover_timer.sv
// Models charge-pump settling after a deep exit.
module lp_recover_timer #(
  parameter int CYCLES = 5625
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  output logic done
);
  localparam int W = (CYCLES < 2) ? 1 : $clog2(CYCLES + 1);
  localparam logic [W-1:0] LOAD_VAL = W'(CYCLES);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;

  always_comb begin
    if (load)
      cnt_d = LOAD_VAL;
    else if (cnt_q != '0)
      cnt_d = cnt_q - 1'b1;
    else
      cnt_d = cnt_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      done  <= 1'b1;
    end else begin
      cnt_q <= cnt_d;
      done  <= (cnt_d == '0);
    end
  end
endmodule

// File: rtl/lp_wake_flag.sv
module lp_wake_flag (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr,
  output logic flag
);
  always_ff @(posedge clk) begin
    if (rst)
      flag <= 1'b0;
    else if (set)
      flag <= 1'b1;
    else if (clr)
      flag <= 1'b0;
  end
endmodule

// File: rtl/lp_power_ctrl.sv
module lp_power_ctrl #(
  parameter int CLK_MHZ    = 125,
  parameter int RECOVER_US = 45
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       sw_sleep_en,
  input  logic       psave_pin,
  input  logic       pump_off_pin,
  input  logic       rx_edge,
  input  logic       host_access,
  input  logic       tx_pending,
  input  logic       rx_fifo_empty,
  input  logic       tx_fifo_empty,
  input  logic       irq_pending,
  input  logic       isr_read,
  output logic       osc_en,
  output logic       pump_en,
  output logic       bus_iso,
  output logic       wake_irq,
  output logic       ready,
  output logic [1:0] mode
);
  import lp_pkg::*;

  localparam int RECOVER_CYCLES = CLK_MHZ * RECOVER_US;

  pm_state_t st_q, st_d;
  logic      exit_any, exit_deep;
  logic      entry_ok, wake_light, wake_psave, recov_done;

  lp_activity u_act (
    .sw_sleep_en  (sw_sleep_en),
    .psave_pin    (psave_pin),
    .rx_edge      (rx_edge),
    .host_access  (host_access),
    .tx_pending   (tx_pending),
    .rx_fifo_empty(rx_fifo_empty),
    .tx_fifo_empty(tx_fifo_empty),
    .irq_pending  (irq_pending),
    .wake_flag    (wake_irq),
    .recov_done   (recov_done),
    .entry_ok     (entry_ok),
    .wake_light   (wake_light),
    .wake_psave   (wake_psave)
  );

  lp_recover_timer #(.CYCLES(RECOVER_CYCLES)) u_tmr (
    .clk (clk),
    .rst (rst),
    .load(exit_deep),
    .done(recov_done)
  );

  lp_wake_flag u_flag (
    .clk (clk),
    .rst (rst),
    .set (exit_any),
    .clr (isr_read),
    .flag(wake_irq)
  );

  always_comb begin
    st_d      = st_q;
    exit_any  = 1'b0;
    exit_deep = 1'b0;
    unique case (st_q)
      PM_AWAKE: begin
        if (entry_ok) begin
          if (psave_pin)        st_d = PM_PSAVE;
          else if (sw_sleep_en) st_d = PM_PARTIAL;
        end
      end
      PM_PARTIAL: begin
        if (wake_light) begin
          st_d     = PM_AWAKE;
          exit_any = 1'b1;
        end else if (psave_pin) begin
          st_d = PM_PSAVE;
        end else if (pump_off_pin) begin
          st_d = PM_FULL;
        end
      end
      PM_FULL: begin
        if (wake_light) begin
          st_d      = PM_AWAKE;
          exit_any  = 1'b1;
          exit_deep = 1'b1;
        end else if (psave_pin) begin
          st_d = PM_PSAVE;
        end
      end
      PM_PSAVE: begin
        if (wake_psave) begin
          st_d      = PM_AWAKE;
          exit_any  = 1'b1;
          exit_deep = 1'b1;
        end
      end
      default: st_d = PM_AWAKE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= PM_AWAKE;
      osc_en  <= 1'b1;
      pump_en <= 1'b1;
      bus_iso <= 1'b0;
    end else begin
      st_q    <= st_d;
      osc_en  <= (st_d == PM_AWAKE);
      pump_en <= (st_d == PM_AWAKE) || (st_d == PM_PARTIAL);
      bus_iso <= (st_d == PM_PSAVE);
    end
  end

  assign mode  = st_q;
  assign ready = osc_en & recov_done;
endmodule

// File: rtl/lp_power_ctrl_chk.sv
module lp_power_ctrl_chk #(
  parameter int CLK_MHZ    = 125,
  parameter int RECOVER_US = 45
) (
  input logic       clk,
  input logic       rst,
  input logic       psave_pin,
  input logic       rx_edge,
  input logic       rx_fifo_empty,
  input logic       tx_fifo_empty,
  input logic       irq_pending,
  input logic       osc_en,
  input logic       pump_en,
  input logic       bus_iso,
  input logic       wake_irq,
  input logic       ready,
  input logic [1:0] mode
);
  localparam int RC = CLK_MHZ * RECOVER_US;

  p_busy_blocks_r2: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'd0 && (!rx_fifo_empty || !tx_fifo_empty || irq_pending)) |=> (mode == 2'd0));

  p_light_pump_r3: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'd1) |-> (pump_en && !osc_en));

  p_no_direct_full_r4: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'd0) |=> (mode != 2'd2));

  p_iso_gates_r5: assert property (@(posedge clk) disable iff (rst)
    bus_iso |-> (!osc_en && !pump_en));

  p_psave_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'd3 && psave_pin && !rx_edge) |=> (mode == 2'd3));

  p_exit_irq_r8: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'd0 && $past(mode) != 2'd0) |-> wake_irq);

  p_deep_recover_r9: assert property (@(posedge clk) disable iff (rst)
    (RC > 0 && mode == 2'd0 && $past(mode) == 2'd2) |-> !ready);
endmodule

bind lp_power_ctrl lp_power_ctrl_chk #(.CLK_MHZ(CLK_MHZ), .RECOVER_US(RECOVER_US)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .psave_pin    (psave_pin),
  .rx_edge      (rx_edge),
  .rx_fifo_empty(rx_fifo_empty),
  .tx_fifo_empty(tx_fifo_empty),
  .irq_pending  (irq_pending),
  .osc_en       (osc_en),
  .pump_en      (pump_en),
  .bus_iso      (bus_iso),
  .wake_irq     (wake_irq),
  .ready        (ready),
  .mode         (mode)
);

// File: tb/lp_power_ctrl_test.sv
`timescale 1ns/1ps
module lp_power_ctrl_test;
  localparam int RCY = 125 * 45;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sw = 0, ps = 0, po = 0, rxe = 0, hacc = 0, txp = 0;
  logic rxemp = 1, txemp = 1, irqp = 0, isrr = 0;
  logic osc_en, pump_en, bus_iso, wake_irq, ready;
  logic [1:0] mode;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  int m_mode = 0;
  int m_rec  = 0;
  bit m_irq  = 0;

  always #4 clk = ~clk;

  lp_power_ctrl uut (
    .clk(clk), .rst(rst), .sw_sleep_en(sw), .psave_pin(ps), .pump_off_pin(po),
    .rx_edge(rxe), .host_access(hacc), .tx_pending(txp),
    .rx_fifo_empty(rxemp), .tx_fifo_empty(txemp), .irq_pending(irqp),
    .isr_read(isrr), .osc_en(osc_en), .pump_en(pump_en), .bus_iso(bus_iso),
    .wake_irq(wake_irq), .ready(ready), .mode(mode)
  );

  function automatic bit f_idle();
    return rxemp && txemp && !irqp && !m_irq && !txp && !hacc && !rxe && (m_rec == 0);
  endfunction

  function automatic bit f_wake_light();
    return rxe || hacc || txp || !sw;
  endfunction

  task automatic model_step();
    int  n = m_mode;
    bit  ex = 0;
    case (m_mode)
      0: begin
        if (f_idle() && ps) n = 3;
        else if (f_idle() && sw) n = 1;
        if (m_rec > 0) m_rec--;
      end
      1: if (f_wake_light()) begin n = 0; ex = 1; m_rec = 0; end
         else if (ps) n = 3;
         else if (po) n = 2;
      2: if (f_wake_light()) begin n = 0; ex = 1; m_rec = RCY; end
         else if (ps) n = 3;
      default: if (rxe || !ps) begin n = 0; ex = 1; m_rec = RCY; end
    endcase
    if (ex) m_irq = 1;
    else if (isrr) m_irq = 0;
    m_mode = n;
  endtask

  task automatic compare(string tag);
    bit e_osc = (m_mode == 0);
    bit e_pmp = (m_mode <= 1);
    bit e_iso = (m_mode == 3);
    bit e_rdy = (m_mode == 0) && (m_rec == 0);
    checks++;
    if (mode !== 2'(m_mode) || osc_en !== e_osc || pump_en !== e_pmp ||
        bus_iso !== e_iso || wake_irq !== m_irq || ready !== e_rdy) begin
      errors++;
      $display("FAIL %s: got mode=%0d osc=%b pump=%b iso=%b irq=%b rdy=%b exp mode=%0d osc=%b pump=%b iso=%b irq=%b rdy=%b",
               tag, mode, osc_en, pump_en, bus_iso, wake_irq, ready,
               m_mode, e_osc, e_pmp, e_iso, m_irq, e_rdy);
    end
  endtask

  task automatic tick(string tag);
    @(posedge clk);
    model_step();
    #1;
    compare(tag);
    @(negedge clk);
    rxe = 0; hacc = 0; isrr = 0;
  endtask

  task automatic expect_bit(string tag, logic got, logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b", tag, got, exp);
    end
  endtask

  // walk the recovery window, checking ready at both ends
  task automatic recover(string tag);
    for (int i = 1; i < RCY; i++) begin
      tick(tag);
    end
    expect_bit(tag, ready, 1'b0);
    tick(tag);
    expect_bit(tag, ready, 1'b1);
  endtask

  initial begin
    repeat (200000 - 2000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got hung run expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1977));
    @(negedge clk);
    repeat (3) @(negedge clk);
    rst = 0;
    #1; compare("R1 reset");
    expect_bit("R1 mode", mode == 2'd0, 1'b1);

    // R4: pump pin while awake does nothing
    po = 1; tick("R4 awake");
    // R2: busy conditions hold the block awake
    sw = 1; rxemp = 0; tick("R2 rx fifo");
    rxemp = 1; irqp = 1; tick("R2 irq");
    irqp = 0; txp = 1; tick("R2 tx pend");
    txp = 0; tick("R3 enter light");
    expect_bit("R3 light osc", osc_en, 1'b0);
    tick("R4 deepen");
    expect_bit("R4 full", mode == 2'd2, 1'b1);
    // R6: host access wakes deep sleep
    hacc = 1; tick("R6 wake");
    expect_bit("R8 irq set", wake_irq, 1'b1);
    recover("R9 full exit");
    tick("R8 irq blocks sleep");
    isrr = 1; tick("R8 clear");
    po = 0;
    tick("R3 light again");
    sw = 0; tick("R6 sw drop");
    expect_bit("R9 light exit ready", ready, 1'b1);
    isrr = 1; tick("R8 clear");

    // R5: power-save pin wins over the register bit
    sw = 1; ps = 1; tick("R5 psave");
    expect_bit("R5 iso", bus_iso, 1'b1);
    hacc = 1; tick("R7 host ignored");
    txp = 1; tick("R7 tx ignored");
    txp = 0; sw = 0; tick("R7 sw ignored");
    expect_bit("R7 still psave", mode == 2'd3, 1'b1);
    rxe = 1; tick("R7 rx wake");
    recover("R9 psave exit");
    isrr = 1; tick("R8 clear");
    tick("R5 psave again");
    ps = 0; isrr = 1; tick("R8 set beats clear");
    expect_bit("R8 set wins", wake_irq, 1'b1);
    recover("R9 pin release");
    isrr = 1; tick("R8 clear");
    sw = 1; tick("R3 light");
    ps = 1; po = 1; tick("R5 from light");
    ps = 0; sw = 0; po = 0; tick("R7 release");
    isrr = 1;
    for (int i = 0; i < 12000; i++) begin
      if ($urandom_range(0, 49) == 0) sw = ~sw;
      if ($urandom_range(0, 99) == 0) ps = ~ps;
      po    = $urandom_range(0, 3) == 0;
      rxe   = $urandom_range(0, 39) == 0;
      hacc  = $urandom_range(0, 39) == 0;
      txp   = $urandom_range(0, 29) == 0;
      rxemp = $urandom_range(0, 19) != 0;
      txemp = $urandom_range(0, 19) != 0;
      irqp  = $urandom_range(0, 24) == 0;
      isrr  = $urandom_range(0, 7) == 0;
      tick("R6 R7 random");
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule